// File: doc/BRIEF.md
# Link-Layer Retry Transmitter

This block sits on the transmit side of a reliable point-to-point link, between a packet source and the serializer. A packet is one payload word. Each accepted packet is given a 12-bit sequence number and a 32-bit check value, and is sent out on the link in a single cycle. A copy of the payload is kept in a small replay store until the far end confirms that the packet arrived.

The receive path decodes acknowledgement messages and passes them in. Each message carries a sequence number and a flag that marks it as a negative acknowledgement. A positive acknowledgement releases the named packet and every older one. A negative acknowledgement also carries the sequence number of the last packet that arrived intact. It releases packets up to that number and then resends every packet still held, oldest first. A replay timer covers lost acknowledgements. If packets are outstanding and nothing releases them for a set number of cycles, the same replay starts. The source is held off while the store is full and while a replay is in progress.

Top module: `rtx_link_tx`

## Requirements
- R1: New packets carry sequence numbers 0, 1, 2, ... after reset, each one more than the last, wrapping from 4095 to 0. The number is driven on `tx_seq` in the same cycle as the packet.
- R2: `tx_crc` is CRC-32 over the 44-bit message {sequence[11:0], payload[31:0]}. The message is fed MSB first, the sequence bits first. The polynomial is 0x04C11DB7, not reflected. The register starts at all ones and the result is inverted.
- R3: When DEPTH packets are unacknowledged, `src_ready` is low and no new packet is sent, even while `src_valid` is held high.
- R4: A message with `ack_nak`=0 and sequence N, where N is outstanding, releases N and every older packet. The comparison is modular over 4096. A message whose N is not outstanding changes nothing.
- R5: A message with `ack_nak`=1 and sequence N first releases packets as in R4, if N is outstanding. It then resends every remaining packet, oldest first, one per cycle. The first resent packet appears in the second cycle after the message is sampled.
- R6: If packets stay outstanding for TIMEOUT cycles without a release and without a replay starting, a replay of all outstanding packets starts. The first resent packet appears TIMEOUT+1 cycles after the event that last restarted the timer.
- R7: `src_ready` is low from the cycle after a replay starts until the last stored packet has been resent.
- R8: After reset, `tx_valid` is low and `src_ready` is high.
- R9: The replay timer restarts whenever an acknowledgement releases at least one packet. It stops while nothing is outstanding.
- R10: A resent packet carries the same sequence number, payload and check value as when it was first sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Source offers a packet |
| src_ready | output | 1 | Block accepts the offered packet this cycle |
| src_data | input | DATA_W | Payload of the offered packet |
| ack_valid | input | 1 | An acknowledgement message is present |
| ack_nak | input | 1 | 1 = negative acknowledgement, 0 = positive |
| ack_seq | input | 12 | Sequence number carried by the message |
| tx_valid | output | 1 | A packet is on the link outputs |
| tx_seq | output | 12 | Sequence number of the packet |
| tx_data | output | DATA_W | Payload of the packet |
| tx_crc | output | 32 | Check value of the packet |

## Verification
A corrupted oldest-pointer or next-number shows up at the ports as a wrong `src_ready` level at the full boundary. It also shows up as a wrong first sequence number in the next replay, visible two cycles after a negative acknowledgement. A timer that restarts at the wrong moment moves the unsolicited replay away from exactly TIMEOUT+1 cycles, so the bench measures that delay to the cycle. A wrong replay pointer or a wrong store index appears immediately as a resent packet whose payload or check value differs from its first transmission.

// File: rtl/rtx_pkg.sv
package rtx_pkg;
  localparam int SEQ_W = 12;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

  typedef logic [SEQ_W-1:0] seq_t;

  // forward distance from b to a, modulo the sequence space
  function automatic seq_t seq_dist(input seq_t a, input seq_t b);
    return seq_t'(a - b);
  endfunction

  // true when s lies within the cnt entries starting at oldest
  function automatic logic seq_in_window(input seq_t s, input seq_t oldest, input seq_t cnt);
    return seq_dist(s, oldest) < cnt;
  endfunction
endpackage

// File: rtl/rtx_crc.sv
module rtx_crc #(
  parameter int IN_W = 44
) (
  input  logic [IN_W-1:0]            msg,
  output logic [rtx_pkg::CRC_W-1:0]  crc
);
  import rtx_pkg::*;

  logic [CRC_W-1:0] acc;
  logic             fb;

  always_comb begin
    acc = '1;
    fb  = 1'b0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      fb  = acc[CRC_W-1] ^ msg[i];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    crc = ~acc;
  end
endmodule

// File: rtl/rtx_store.sv
module rtx_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/rtx_timer.sv
module rtx_timer #(
  parameter int TIMEOUT = 256,
  localparam int CNT_W  = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic expire
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt;

  assign expire = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                       cnt <= '0;
    else if (!run || restart || expire) cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end

  // R6: the count never passes the timeout limit
  p_timer_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(TIMEOUT));

  // R9: an idle timer holds at zero
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
endmodule

// File: rtl/rtx_window.sv
module rtx_window #(
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          send,
  input  logic          ack_valid,
  input  rtx_pkg::seq_t ack_seq,
  output rtx_pkg::seq_t next_seq,
  output rtx_pkg::seq_t una_n,
  output rtx_pkg::seq_t count,
  output rtx_pkg::seq_t count_n,
  output logic          hit
);
  import rtx_pkg::*;

  localparam seq_t DEPTH_S = seq_t'(DEPTH);

  seq_t una;
  seq_t next_n;

  assign count   = seq_dist(next_seq, una);
  assign hit     = ack_valid && seq_in_window(ack_seq, una, count);
  assign una_n   = hit ? seq_t'(ack_seq + 1'b1) : una;
  assign next_n  = send ? seq_t'(next_seq + 1'b1) : next_seq;
  assign count_n = seq_dist(next_n, una_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      una      <= '0;
      next_seq <= '0;
    end else begin
      una      <= una_n;
      next_seq <= next_n;
    end
  end

  // R3: outstanding packets never exceed the store size
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH_S);

  // R4: a matching acknowledgement strictly shrinks the window
  p_ack_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !send |=> count < $past(count));

  // R4: a message naming no outstanding packet leaves the oldest untouched
  p_stale_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && !hit |=> una == $past(una));
endmodule

// File: rtl/rtx_link_tx.sv
module rtx_link_tx #(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 8,
  parameter int TIMEOUT = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       src_valid,
  output logic                       src_ready,
  input  logic [DATA_W-1:0]          src_data,
  input  logic                       ack_valid,
  input  logic                       ack_nak,
  input  logic [rtx_pkg::SEQ_W-1:0]  ack_seq,
  output logic                       tx_valid,
  output logic [rtx_pkg::SEQ_W-1:0]  tx_seq,
  output logic [DATA_W-1:0]          tx_data,
  output logic [rtx_pkg::CRC_W-1:0]  tx_crc
);
  import rtx_pkg::*;

  // DEPTH must be a power of two between 2 and 2048 (half the sequence space)
  localparam int   IDX_W   = $clog2(DEPTH);
  localparam int   MSG_W   = SEQ_W + DATA_W;
  localparam seq_t DEPTH_S = seq_t'(DEPTH);

  // window state
  seq_t next_seq, una_n, count, count_n;
  logic hit;

  // replay state
  logic replaying;
  seq_t rp_seq;

  // named internal events
  logic send_new, start_replay, tmr_expire, emit_replay, rp_ok;
  seq_t rp_cur, out_seq;
  logic [DATA_W-1:0] rd_data, out_data;
  logic [CRC_W-1:0]  out_crc;

  assign src_ready    = !replaying && (count < DEPTH_S);
  assign send_new     = src_valid && src_ready;
  assign start_replay = (ack_valid && ack_nak) || tmr_expire;
  assign rp_ok        = seq_in_window(rp_seq, una_n, count_n);
  assign rp_cur       = rp_ok ? rp_seq : una_n;
  assign emit_replay  = replaying && !start_replay && (count_n != '0);

  rtx_window #(.DEPTH(DEPTH)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .send     (send_new),
    .ack_valid(ack_valid),
    .ack_seq  (ack_seq),
    .next_seq (next_seq),
    .una_n    (una_n),
    .count    (count),
    .count_n  (count_n),
    .hit      (hit)
  );

  rtx_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (count != '0),
    .restart(hit || start_replay),
    .expire (tmr_expire)
  );

  rtx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .wr_en  (send_new),
    .wr_idx (next_seq[IDX_W-1:0]),
    .wr_data(src_data),
    .rd_idx (rp_cur[IDX_W-1:0]),
    .rd_data(rd_data)
  );

  assign out_seq  = emit_replay ? rp_cur  : next_seq;
  assign out_data = emit_replay ? rd_data : src_data;

  rtx_crc #(.IN_W(MSG_W)) u_crc (
    .msg({out_seq, out_data}),
    .crc(out_crc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      replaying <= 1'b0;
      rp_seq    <= '0;
      tx_valid  <= 1'b0;
      tx_seq    <= '0;
      tx_data   <= '0;
      tx_crc    <= '0;
    end else begin
      if (start_replay) begin
        replaying <= (count_n != '0);
        rp_seq    <= una_n;
      end else if (replaying) begin
        if (count_n == '0) begin
          replaying <= 1'b0;
        end else begin
          rp_seq    <= seq_t'(rp_cur + 1'b1);
          replaying <= (seq_t'(rp_cur + 1'b1) != next_seq);
        end
      end
      tx_valid <= send_new || emit_replay;
      if (send_new || emit_replay) begin
        tx_seq  <= out_seq;
        tx_data <= out_data;
        tx_crc  <= out_crc;
      end
    end
  end

  // R1: a newly accepted packet leaves with the window's next number
  p_seq_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    send_new |=> tx_valid && tx_seq == $past(next_seq));

  // R5: a replay request with packets left starts a replay
  p_replay_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_replay && count_n != '0 |=> replaying);

  // R5: consecutive resent packets follow sequence order
  p_replay_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    emit_replay && $past(emit_replay) && !hit |-> rp_cur == seq_t'($past(rp_cur) + 1'b1));

  // R7: no new number is issued while a replay continues
  p_replay_no_new_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(replaying) && replaying |-> next_seq == $past(next_seq));
endmodule

// File: tb/rtx_link_tx_bench.sv
module rtx_link_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 32;
  localparam int DEP  = 4;
  localparam int TOUT = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic src_valid = 1'b0;
  logic src_ready;
  logic [DW-1:0] src_data = '0;
  logic ack_valid = 1'b0;
  logic ack_nak = 1'b0;
  logic [11:0] ack_seq = '0;
  logic tx_valid;
  logic [11:0] tx_seq;
  logic [DW-1:0] tx_data;
  logic [31:0] tx_crc;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [11:0] exp_next = '0;
  logic [DW-1:0] sent [16];
  logic [11:0] lg_seq [256];
  logic [DW-1:0] lg_data [256];
  logic [31:0] lg_crc [256];
  int lg_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtx_link_tx #(.DATA_W(DW), .DEPTH(DEP), .TIMEOUT(TOUT)) u_rtx_link_tx (
    .clk(clk), .rst_n(rst_n),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .ack_valid(ack_valid), .ack_nak(ack_nak), .ack_seq(ack_seq),
    .tx_valid(tx_valid), .tx_seq(tx_seq), .tx_data(tx_data), .tx_crc(tx_crc)
  );

  // link monitor: one entry per transmitted packet
  always @(posedge clk) begin
    #1;
    if (rst_n && tx_valid) begin
      lg_seq[lg_n % 256]  = tx_seq;
      lg_data[lg_n % 256] = tx_data;
      lg_crc[lg_n % 256]  = tx_crc;
      lg_n++;
    end
  end

  // polynomial long division of the preset message
  function automatic logic [31:0] ref_crc(input logic [11:0] s, input logic [31:0] d);
    logic [75:0] m;
    m = {({s, d} ^ {32'hFFFF_FFFF, 12'h000}), 32'h0};
    for (int i = 75; i >= 32; i--)
      if (m[i]) m[i -: 33] = m[i -: 33] ^ {1'b1, 32'h04C1_1DB7};
    return ~m[31:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic chk_entry(input int idx, input logic [11:0] s, input string tag);
    chk(lg_seq[idx % 256] == s, {tag, " seq"}, 64'(lg_seq[idx % 256]), 64'(s));
    chk(lg_data[idx % 256] == sent[s[3:0]], {tag, " data"}, 64'(lg_data[idx % 256]), 64'(sent[s[3:0]]));
    chk(lg_crc[idx % 256] == ref_crc(s, sent[s[3:0]]), {tag, " crc R2"},
        64'(lg_crc[idx % 256]), 64'(ref_crc(s, sent[s[3:0]])));
  endtask

  task automatic push(input logic [DW-1:0] d);
    while (!src_ready) @(negedge clk);
    src_valid = 1'b1;
    src_data  = d;
    sent[exp_next[3:0]] = d;
    exp_next = exp_next + 1'b1;
    @(negedge clk);
    src_valid = 1'b0;
  endtask

  task automatic send_ack(input logic nak, input logic [11:0] s);
    ack_valid = 1'b1;
    ack_nak   = nak;
    ack_seq   = s;
    @(negedge clk);
    ack_valid = 1'b0;
    ack_nak   = 1'b0;
  endtask

  task automatic t_reset;
    chk(tx_valid == 1'b0, "R8 tx_valid after reset", 64'(tx_valid), 64'd0);
    chk(src_ready == 1'b1, "R8 src_ready after reset", 64'(src_ready), 64'd1);
  endtask

  task automatic t_basic;
    int n0 = lg_n;
    push(32'hA5A5_0001);
    push(32'h1234_5678);
    push(32'hFFFF_0000);
    chk(lg_n == n0 + 3, "R1 three packets sent", 64'(lg_n - n0), 64'd3);
    chk_entry(n0,     12'd0, "R1 first");
    chk_entry(n0 + 1, 12'd1, "R1 second");
    chk_entry(n0 + 2, 12'd2, "R1 third");
  endtask

  task automatic t_full;
    int n0;
    push(32'h0BAD_CAFE);
    chk(src_ready == 1'b0, "R3 ready low when full", 64'(src_ready), 64'd0);
    n0 = lg_n;
    src_valid = 1'b1;
    src_data  = 32'hDEAD_0000;
    repeat (3) @(negedge clk);
    src_valid = 1'b0;
    chk(lg_n == n0, "R3 nothing sent while full", 64'(lg_n - n0), 64'd0);
  endtask

  task automatic t_ack;
    int n0;
    send_ack(1'b0, 12'd1);
    chk(src_ready == 1'b1, "R4 ack releases space", 64'(src_ready), 64'd1);
    n0 = lg_n;
    send_ack(1'b0, 12'd0);
    push(32'h4444_4444);
    push(32'h5555_5555);
    chk(src_ready == 1'b0, "R4 stale ack ignored, full after two", 64'(src_ready), 64'd0);
    chk(lg_n == n0 + 2, "R4 stale ack caused no replay", 64'(lg_n - n0), 64'd2);
  endtask

  task automatic t_nak_timeout;
    int n0 = lg_n;
    int first = -1;
    send_ack(1'b1, 12'd3);
    chk(src_ready == 1'b0, "R7 ready low in replay", 64'(src_ready), 64'd0);
    for (int n = 1; n <= TOUT + 4; n++) begin
      @(negedge clk);
      if (n == 3) chk(src_ready == 1'b1, "R7 ready back after replay", 64'(src_ready), 64'd1);
      if (first < 0 && lg_n >= n0 + 3) first = n;
    end
    chk(lg_n == n0 + 4, "R5 R6 replay counts", 64'(lg_n - n0), 64'd4);
    chk_entry(n0,     12'd4, "R5 R10 nak replay 1");
    chk_entry(n0 + 1, 12'd5, "R5 R10 nak replay 2");
    chk(first == TOUT + 1, "R6 timeout replay delay", 64'(first), 64'(TOUT + 1));
    chk_entry(n0 + 2, 12'd4, "R6 timeout replay 1");
    chk_entry(n0 + 3, 12'd5, "R6 timeout replay 2");
  endtask

  task automatic t_restart;
    int n0;
    int first = -1;
    send_ack(1'b0, 12'd5);
    n0 = lg_n;
    repeat (2 * TOUT) @(negedge clk);
    chk(lg_n == n0, "R9 timer stopped when empty", 64'(lg_n - n0), 64'd0);
    push(32'h6666_6666);
    push(32'h7777_7777);
    repeat (20) @(negedge clk);
    n0 = lg_n;
    send_ack(1'b0, 12'd6);
    for (int n = 1; n <= TOUT + 3; n++) begin
      @(negedge clk);
      if (first < 0 && lg_n > n0) first = n;
    end
    chk(first == TOUT + 1, "R9 timer restarted by ack", 64'(first), 64'(TOUT + 1));
    chk_entry(n0, 12'd7, "R9 replay after restart");
    send_ack(1'b0, 12'd7);
  endtask

  task automatic t_nak_none;
    int n0;
    push(32'h8888_0008);
    push(32'h9999_0009);
    push(32'hAAAA_000A);
    n0 = lg_n;
    send_ack(1'b1, 12'd7);
    chk(src_ready == 1'b0, "R7 ready low in full replay", 64'(src_ready), 64'd0);
    repeat (4) @(negedge clk);
    chk(lg_n == n0 + 3, "R5 all outstanding resent", 64'(lg_n - n0), 64'd3);
    chk_entry(n0,     12'd8,  "R5 order 1");
    chk_entry(n0 + 1, 12'd9,  "R5 order 2");
    chk_entry(n0 + 2, 12'd10, "R5 order 3");
    send_ack(1'b0, 12'd10);
  endtask

  task automatic t_wrap;
    int n0;
    while (exp_next != 12'd4095) begin
      push({20'h0, exp_next} ^ 32'h3C3C_0000);
      send_ack(1'b0, exp_next - 1'b1);
    end
    n0 = lg_n;
    push(32'hFEED_0FFF);
    push(32'hBEEF_0000);
    chk_entry(n0,     12'd4095, "R1 last before wrap");
    chk_entry(n0 + 1, 12'd0,    "R1 wrapped to zero");
    send_ack(1'b0, 12'd0);
    push(32'h1);
    push(32'h2);
    push(32'h3);
    chk(src_ready == 1'b1, "R4 modular ack freed both", 64'(src_ready), 64'd1);
    push(32'h4);
    chk(src_ready == 1'b0, "R3 full after wrap", 64'(src_ready), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_full();
    t_ack();
    t_nak_timeout();
    t_restart();
    t_nak_none();
    t_wrap();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule